// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The aggregator collects level-sensitive interrupt lines, organised in groups of 32, and folds them into a single interrupt request toward a parent interrupt controller. A parameter sets the number of groups, from 1 to 16, so the block serves up to 512 lines. Each line passes through a two-stage synchronizer and is then captured in a per-group raw word. A per-group enable word gates the raw word, and the result is a per-group pending word. A summary register shows which line groups have an enabled line pending. The output request is raised when any enabled line is pending, the channel is switched on, and the master kill bit is clear.

Software uses a 32-bit register port with separate read and write strobes. The register offsets are not fixed. They follow from the group count, so one driver can serve every size. A second parameter reverses which register word serves which line group. Lines carry no acknowledge. A pending bit stays set until its source drops the line.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable word, the channel switch and the master kill bit are 0, the read data is 0 and `irq_o` is low.
- R2: With G groups and S = 4*G, the registers sit at these byte offsets:
  - channel switch at 0x0
  - enable word n at 0x4+4n
  - raw word n at 0x4+4n+S
  - pending word n at 0x4+4n+2S
  - master kill at 0x4+3S
  - summary at 0x8+3S

  A read of any other offset returns 0. A write to any other offset changes nothing.
- R3: With normal ordering (REVERSED=0), bit b of word n of the enable, raw and pending registers stands for line 32n+b.
- R4: With REVERSED=1, word n of the enable, raw and pending registers serves line group G-1-n, and bit b still stands for line 32*(G-1-n)+b.
- R5: A change on a line becomes visible in its raw word on the third rising clock edge after the change. A read that captures on that third edge still returns the old value.
- R6: A pending word equals its raw word ANDed with the enable word of the same line group. An enable bit of 1 passes the line and 0 blocks it. Read-modify-write of an enable word changes only the bits that are written differently.
- R7: Summary bit g is 1 exactly when line group g has at least one enabled line pending. Bits G and above read 0.
- R8: `irq_o` equals (channel switch bit 0) AND NOT (master kill bit 0) AND (any pending bit set). The output is combinational from the registers.
- R9: Reads have no side effects. A pending bit remains set across any number of reads and clears only after its line is deasserted. `reg_rdata_o` changes only in a cycle with `reg_rd_i` high.
- R10: Writes to the raw words, the pending words and the summary register are ignored.
- R11: The channel switch and master kill registers keep only bit 0 of a write. A read of either returns that bit in position 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32*NUM_GROUPS | Level interrupt sources; bit 32g+b is line b of group g |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe; data is captured on the same clock edge |
| reg_rdata_o | output | 32 | Read data, valid from the edge that follows the strobe |
| irq_o | output | 1 | Aggregated interrupt request to the parent controller |

## Verification
Two things can land on the same clock edge: a raw word capturing a new line value, and a read of that word. The bench provokes this by changing a line and then timing a read strobe so that its capture edge is exactly the third edge after the change. That read must return the old word, and the read on the next edge must return the new one. This is repeated for every one of the 64 lines of a two-group configuration, in both orderings. Enable writes that land while lines are held high are judged the same way: the pending word, the summary and `irq_o` are compared against a model in the bench that recomputes them from the line vector and the written enable words.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int LINES_PER_GRP = 32;
  localparam int REG_W         = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CHAN,
    SEL_MASK,
    SEL_RAW,
    SEL_PEND,
    SEL_KILL,
    SEL_SUM
  } reg_sel_e;

  // byte offsets, all derived from the group count
  function automatic int span(input int groups);
    return 4 * groups;
  endfunction

  function automatic int mask_off(input int n, input int groups);
    return 4 + 4 * n + 0 * groups;
  endfunction

  function automatic int raw_off(input int n, input int groups);
    return 4 + 4 * n + span(groups);
  endfunction

  function automatic int pend_off(input int n, input int groups);
    return 4 + 4 * n + 2 * span(groups);
  endfunction

  function automatic int kill_off(input int groups);
    return 4 + 3 * span(groups);
  endfunction

  function automatic int sum_off(input int groups);
    return kill_off(groups) + 4;
  endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter bit REVERSED   = 1'b0,
  parameter int ADDR_W     = 8,
  localparam int IDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  grp_o
);

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  always_comb begin
    sel_o = SEL_NONE;
    grp_o = '0;
    if (addr_ext == 32'd0) sel_o = SEL_CHAN;
    if (addr_ext == 32'(kill_off(NUM_GROUPS))) sel_o = SEL_KILL;
    if (addr_ext == 32'(sum_off(NUM_GROUPS)))  sel_o = SEL_SUM;
    for (int n = 0; n < NUM_GROUPS; n++) begin
      // word n serves group n, or the mirrored group when reversed
      if (addr_ext == 32'(mask_off(n, NUM_GROUPS))) begin
        sel_o = SEL_MASK;
        grp_o = REVERSED ? IDX_W'(NUM_GROUPS - 1 - n) : IDX_W'(n);
      end
      if (addr_ext == 32'(raw_off(n, NUM_GROUPS))) begin
        sel_o = SEL_RAW;
        grp_o = REVERSED ? IDX_W'(NUM_GROUPS - 1 - n) : IDX_W'(n);
      end
      if (addr_ext == 32'(pend_off(n, NUM_GROUPS))) begin
        sel_o = SEL_PEND;
        grp_o = REVERSED ? IDX_W'(NUM_GROUPS - 1 - n) : IDX_W'(n);
      end
    end
  end

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] pend_o,
  output logic         any_o
);

  logic [W-1:0] mask_q, raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= lines_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign mask_o = mask_q;
  assign raw_o  = raw_q;
  assign pend_o = raw_q & mask_q;
  assign any_o  = |pend_o;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q)); // R2

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter bit REVERSED   = 1'b0,
  parameter int ADDR_W     = 8,
  localparam int NUM_LINES = NUM_GROUPS * LINES_PER_GRP,
  localparam int IDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  input  logic                 reg_rd_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] lines_sync;
  reg_sel_e             sel;
  logic [IDX_W-1:0]     grp;
  logic [REG_W-1:0]     mask_w [NUM_GROUPS];
  logic [REG_W-1:0]     raw_w  [NUM_GROUPS];
  logic [REG_W-1:0]     pend_w [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_any;
  logic [NUM_GROUPS-1:0] grp_masked;
  logic                 chan_q, kill_q;
  logic [REG_W-1:0]     rd_mux, rdata_q;

  irq_agg_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_lines_i),
    .sync_o (lines_sync)
  );

  irq_agg_decode #(
    .NUM_GROUPS(NUM_GROUPS),
    .REVERSED  (REVERSED),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .addr_i(reg_addr_i),
    .sel_o (sel),
    .grp_o (grp)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_agg_group #(.W(LINES_PER_GRP)) u_grp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lines_i     (lines_sync[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .mask_we_i   (reg_wr_i && (sel == SEL_MASK) && (grp == IDX_W'(g))),
      .mask_wdata_i(reg_wdata_i),
      .mask_o      (mask_w[g]),
      .raw_o       (raw_w[g]),
      .pend_o      (pend_w[g]),
      .any_o       (grp_any[g])
    );
    assign grp_masked[g] = |mask_w[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= 1'b0;
      kill_q <= 1'b0;
    end else if (reg_wr_i) begin
      if (sel == SEL_CHAN) chan_q <= reg_wdata_i[0];
      if (sel == SEL_KILL) kill_q <= reg_wdata_i[0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CHAN: rd_mux = {{(REG_W-1){1'b0}}, chan_q};
      SEL_KILL: rd_mux = {{(REG_W-1){1'b0}}, kill_q};
      SEL_MASK: rd_mux = mask_w[grp];
      SEL_RAW:  rd_mux = raw_w[grp];
      SEL_PEND: rd_mux = pend_w[grp];
      SEL_SUM:  rd_mux = REG_W'(grp_any);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = chan_q && !kill_q && (|grp_any);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|grp_masked)); // R6

  AST_KILL_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel == SEL_KILL && reg_wdata_i[0]) |=> !irq_o); // R8

  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> $stable(chan_q)); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R9

endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

  localparam int G = 2;
  localparam int S = 4 * G;
  localparam logic [7:0] A_CHAN = 8'h00;
  localparam logic [7:0] A_KILL = 8'(4 + 3 * S);
  localparam logic [7:0] A_SUM  = 8'(8 + 3 * S);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [31:0] mask_m [2];
  logic        chan_m = 1'b0, kill_m = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator #(.NUM_GROUPS(G), .REVERSED(1'b0), .ADDR_W(8)) u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata_a), .irq_o(irq_a)
  );

  irq_aggregator #(.NUM_GROUPS(G), .REVERSED(1'b1), .ADDR_W(8)) u_irq_aggregator_rev (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata_b), .irq_o(irq_b)
  );

  function automatic logic [7:0] a_mask(int n); return 8'(4 + 4 * n); endfunction
  function automatic logic [7:0] a_raw(int n);  return 8'(4 + 4 * n + S); endfunction
  function automatic logic [7:0] a_pend(int n); return 8'(4 + 4 * n + 2 * S); endfunction

  function automatic logic [31:0] grp_lines(int g);
    return lines[32*g +: 32];
  endfunction
  function automatic logic [31:0] exp_raw(bit rev, int w);
    return grp_lines(rev ? G - 1 - w : w);
  endfunction
  function automatic logic [31:0] exp_pend(bit rev, int w);
    return exp_raw(rev, w) & mask_m[w];
  endfunction
  function automatic logic [31:0] exp_sum(bit rev);
    logic [31:0] s = '0;
    for (int g = 0; g < G; g++) s[g] = |(grp_lines(g) & mask_m[rev ? G - 1 - g : g]);
    return s;
  endfunction
  function automatic logic exp_irq(bit rev);
    return chan_m && !kill_m && (exp_sum(rev) != 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
    addr = a; rd = 1'b1;
    tick();
    rd = 1'b0;
    da = rdata_a; db = rdata_b;
  endtask

  task automatic set_mask(input int w, input logic [31:0] v);
    reg_write(a_mask(w), v);
    mask_m[w] = v;
  endtask

  task automatic check_all(input string req);
    logic [31:0] da, db;
    for (int w = 0; w < G; w++) begin
      reg_read(a_mask(w), da, db);
      chk({req, " mask A"}, da, mask_m[w]);
      chk({req, " mask B"}, db, mask_m[w]);
      reg_read(a_raw(w), da, db);
      chk({req, " raw A"}, da, exp_raw(1'b0, w));
      chk({req, " raw B"}, db, exp_raw(1'b1, w));
      reg_read(a_pend(w), da, db);
      chk({req, " pend A"}, da, exp_pend(1'b0, w));
      chk({req, " pend B"}, db, exp_pend(1'b1, w));
    end
    reg_read(A_SUM, da, db);
    chk({req, " sum A"}, da, exp_sum(1'b0));
    chk({req, " sum B"}, db, exp_sum(1'b1));
    reg_read(A_CHAN, da, db);
    chk({req, " chan A"}, da, {31'b0, chan_m});
    chk({req, " chan B"}, db, {31'b0, chan_m});
    reg_read(A_KILL, da, db);
    chk({req, " kill A"}, da, {31'b0, kill_m});
    chk({req, " kill B"}, db, {31'b0, kill_m});
    chk({req, " irq A"}, 32'(irq_a), 32'(exp_irq(1'b0)));
    chk({req, " irq B"}, 32'(irq_b), 32'(exp_irq(1'b1)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] da, db;
    logic [63:0] prev;
    mask_m[0] = '0; mask_m[1] = '0;
    repeat (3) tick();
    // R1: reset state, checked while still in reset and after release
    chk("R1 irq A in reset", 32'(irq_a), 32'd0);
    chk("R1 rdata A in reset", rdata_a, 32'd0);
    rst_n = 1'b1;
    tick();
    check_all("R1");

    // R2: unmapped offsets read zero
    reg_read(8'h24, da, db);
    chk("R2 unmapped A", da, 32'd0);
    chk("R2 unmapped B", db, 32'd0);
    reg_read(8'hFC, da, db);
    chk("R2 unmapped high A", da, 32'd0);

    // R3 R4 R5: walk one line through all 64, both orderings, latency edge
    for (int l = 0; l < 64; l++) begin
      prev = lines;
      lines = 64'(1) << l;
      tick(); tick();
      reg_read(a_raw(l / 32), da, db);
      chk("R5 raw old on third edge", da, prev[32*(l/32) +: 32]);
      reg_read(a_raw(l / 32), da, db);
      chk("R3 raw word new", da, 32'(1) << (l % 32));
      reg_read(a_raw(G - 1 - l / 32), da, db);
      chk("R4 reversed raw word", db, 32'(1) << (l % 32));
    end

    // R6 R7: pending words and summary under mixed patterns
    lines = 64'hA5A5_A5A5_1234_5678;
    chan_m = 1'b1;
    reg_write(A_CHAN, 32'd1);
    set_mask(0, 32'h0000_FFFF);
    set_mask(1, 32'hF0F0_F0F0);
    repeat (3) tick();
    check_all("R6");
    set_mask(0, 32'h0);
    set_mask(1, 32'h0);
    check_all("R7 all blocked");
    set_mask(0, 32'h0000_0008);
    check_all("R7 one word");
    // R6: read-modify-write touches one bit
    reg_read(a_mask(1), da, db);
    set_mask(1, da | 32'h0000_0020);
    check_all("R6 rmw");

    // R8: gate sweep over switch, kill and pending
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 2; k++)
        for (int p = 0; p < 2; p++) begin
          chan_m = c[0]; kill_m = k[0];
          reg_write(A_CHAN, {31'h7FFF_FFFF, c[0]});
          reg_write(A_KILL, {31'h0000_0000, k[0]});
          set_mask(0, p ? 32'hFFFF_FFFF : 32'h0);
          set_mask(1, p ? 32'hFFFF_FFFF : 32'h0);
          chk("R8 irq A", 32'(irq_a), 32'(exp_irq(1'b0)));
          chk("R8 irq B", 32'(irq_b), 32'(exp_irq(1'b1)));
        end
    check_all("R11");

    // R9: level hold across reads, clear only when source drops
    chan_m = 1'b1; kill_m = 1'b0;
    reg_write(A_CHAN, 32'd1);
    reg_write(A_KILL, 32'd0);
    lines = 64'h0000_0001_8000_0000;
    repeat (4) tick();
    for (int i = 0; i < 3; i++) check_all("R9 hold");
    lines = '0;
    tick();
    chk("R9 irq still up before sync", 32'(irq_a), 32'd1);
    repeat (3) tick();
    check_all("R9 cleared");

    // R10: writes to read-only words ignored
    lines = 64'h0F0F_0000_0000_F0F0;
    repeat (4) tick();
    for (int w = 0; w < G; w++) begin
      reg_write(a_raw(w), 32'hFFFF_FFFF);
      reg_write(a_pend(w), 32'hFFFF_FFFF);
    end
    reg_write(A_SUM, 32'hFFFF_FFFF);
    reg_write(8'h24, 32'hFFFF_FFFF);
    check_all("R10");

    // R11: only bit 0 of switch and kill retained
    reg_write(A_CHAN, 32'hFFFF_FFFE);
    chan_m = 1'b0;
    reg_write(A_KILL, 32'h0000_0003);
    kill_m = 1'b1;
    check_all("R11 bit0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule